// File: doc/BRIEF.md
# Processor Sleep and Wake-Event Controller

This block decides when a processor core goes into a low-power state and when it comes out again. A memory-mapped control word selects three things: the sleep depth, whether the core returns to sleep after an exception return to thread mode, and whether any newly pending interrupt counts as a wake event, including a disabled one. The core reports each executed wait-for-interrupt, wait-for-event and send-event instruction as a one-cycle strobe. It also reports each exception return to thread mode the same way.

A one-bit event latch records events that arrive while the core is not waiting for one. The next wait-for-event consumes the latch and completes at once, without sleeping. While the core sleeps, the block watches the interrupt pending and enable vectors and the event sources. When the wake condition for the current kind of sleep is met, it raises a wake pulse for one cycle and leaves the sleeping state on the next clock edge. The deep-sleep indication tells the clock and power logic outside the block how far to shut down.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, and after any later reset, the control word reads 0, sleeping, deep_sleep and wake_pulse are 0, and the event latch is clear, so a first wait-for-event goes to sleep.
- R2: The control word sits at byte address 0xD10. Bit 4 is the pend-event enable, bit 2 the deep-sleep select and bit 1 the sleep-on-exit enable. All other bits read 0 and ignore writes. Any other address reads 0, and writes to it have no effect.
- R3: A wait-for-interrupt strobe while awake sets sleeping from the next cycle. That sleep ends only when some interrupt is both pending and enabled. A pending but disabled interrupt does not end it.
- R4: A wait-for-event strobe while the event latch is clear enters sleep. While the latch is set, the strobe clears the latch and the core stays awake.
- R5: A send-event strobe or the external event input raises wake_pulse at once while the core sleeps in wait-for-event. In any other state, including a wait-for-interrupt sleep, it sets the event latch instead.
- R6: With bit 4 at 0, a disabled interrupt becoming pending neither wakes a wait-for-event sleep nor sets the latch. An enabled interrupt becoming pending does wake it.
- R7: With bit 4 at 1, any interrupt becoming pending is an event, whether or not it is enabled.
- R8: Only the 0-to-1 transition of a pending bit makes an event. A pending level that stays high makes no further events.
- R9: With bit 1 at 1, an exception-return strobe while awake enters sleep with the same wake rule as R3. With bit 1 at 0, the strobe has no effect.
- R10: deep_sleep is 1 exactly when sleeping is 1 and bit 2 is 1.
- R11: wake_pulse is 1 only while the core sleeps and its wake condition holds. sleeping is 0 on the cycle after the pulse, so the pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write enable, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| wfi_exec | input | 1 | Wait-for-interrupt executed |
| wfe_exec | input | 1 | Wait-for-event executed |
| sev_exec | input | 1 | Send-event executed |
| ext_event | input | 1 | External event pulse |
| exc_ret_thread | input | 1 | Exception return to thread mode |
| irq_pend | input | N_IRQ | Interrupt pending vector |
| irq_en | input | N_IRQ | Interrupt enable vector |
| sleeping | output | 1 | Core is in a low-power state |
| deep_sleep | output | 1 | Low-power state is the deep one |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
The properties take for granted that the instruction strobes last a single cycle and that at most one of wait-for-interrupt, wait-for-event and exception return is asserted in any cycle. They also assume that the pending and enable vectors are synchronous to clk. The stimulus changes every input only on the falling edge and raises at most one instruction strobe per step. Pending bits are raised and held across several steps, so that both the edge detection and the level-based wake condition are exercised.

// File: rtl/slpw_pkg.sv
// Package: shared types and field positions for the sleep/wake controller.
// Assumes: the control word is at most 32 bits wide.
package slpw_pkg;

    // Field positions inside the control word
    localparam int PENDEV_BIT = 4;
    localparam int DEEP_BIT   = 2;
    localparam int EXIT_BIT   = 1;

    // Decoded configuration seen by the rest of the block
    typedef struct packed {
        logic pend_event;
        logic deep;
        logic on_exit;
    } slp_cfg_t;

    // Sleep state: awake, or the kind of sleep entered
    typedef enum logic [1:0] {
        SLP_AWAKE = 2'd0,
        SLP_WFI   = 2'd1,
        SLP_WFE   = 2'd2,
        SLP_EXIT  = 2'd3
    } slp_state_e;

endpackage

// File: rtl/slpw_cfg_reg.sv
// Module: control word register with a single-cycle bus.
// Keeps only the three writable fields; reserved bits are masked to zero.
// Assumes: bus_wr is a one-cycle strobe; the read path is combinational.
module slpw_cfg_reg
    import slpw_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          DATA_W  = 32,
    parameter logic [11:0] CFG_OFS = 12'hD10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output slp_cfg_t          cfg
);
    localparam logic [DATA_W-1:0] RW_MASK =
        (DATA_W'(1) << PENDEV_BIT) | (DATA_W'(1) << DEEP_BIT) | (DATA_W'(1) << EXIT_BIT);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CFG_OFS);

    logic              hit;
    logic [DATA_W-1:0] word_q;

    assign hit = (bus_addr == OFS);

    // Store writable bits on a write to the control address
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (bus_wr && hit)
            word_q <= bus_wdata & RW_MASK;
    end

    // Return the word only for the control address
    always_comb begin
        bus_rdata = hit ? word_q : '0;
    end

    // Break the word into named fields
    always_comb begin
        cfg.pend_event = word_q[PENDEV_BIT];
        cfg.deep       = word_q[DEEP_BIT];
        cfg.on_exit    = word_q[EXIT_BIT];
    end
endmodule

// File: rtl/slpw_event_unit.sv
// Module: event source merge, pending-edge detection and the event latch.
// An event is SEV, the external input, or a pending bit rising (enabled
// only, or any when pend_event is set). The latch remembers events not
// used to end a wait-for-event sleep; a wait-for-event taken while awake
// always leaves it clear.
// Assumes: irq_pend and irq_en are synchronous to clk.
module slpw_event_unit #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_event,
    input  logic             sev,
    input  logic             ext,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wfe_take,
    input  logic             in_wfe,
    output logic             event_now,
    output logic             latch_q,
    output logic             irq_ready
);
    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] rise;
    logic [N_IRQ-1:0] rise_sel;
    logic             latch_d;

    // Remember last pending vector for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= irq_pend;
    end

    // Pick which rising pending bits count as events
    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_rise
            assign rise[g]     = irq_pend[g] & ~pend_q[g];
            assign rise_sel[g] = rise[g] & (pend_event | irq_en[g]);
        end
    endgenerate

    // Merge event sources and the level wake condition
    always_comb begin
        event_now = sev | ext | (|rise_sel);
        irq_ready = |(irq_pend & irq_en);
    end

    // Latch next state: WFE clears it, otherwise events outside WFE set it
    always_comb begin
        if (wfe_take)
            latch_d = 1'b0;
        else if (event_now && !in_wfe)
            latch_d = 1'b1;
        else
            latch_d = latch_q;
    end

    // Event latch register
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= 1'b0;
        else
            latch_q <= latch_d;
    end
endmodule

// File: rtl/slpw_sleep_fsm.sv
// Module: sleep state machine. Enters sleep on WFI, on WFE without a
// pending event, or on exception return with sleep-on-exit; leaves it
// when the wake condition for the current sleep kind holds.
// Assumes: instruction strobes are single-cycle; WFI has priority.
module slpw_sleep_fsm
    import slpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_go,
    input  logic       wfe_go,
    input  logic       exc_ret,
    input  logic       on_exit,
    input  logic       event_now,
    input  logic       latch_q,
    input  logic       irq_ready,
    output slp_state_e state,
    output logic       wake
);
    slp_state_e state_d;
    logic       wfe_hit;

    // A WFE finds an event either stored or arriving this cycle
    assign wfe_hit = latch_q | event_now;

    // Wake condition for the current sleep kind
    always_comb begin
        case (state)
            SLP_WFI, SLP_EXIT: wake = irq_ready;
            SLP_WFE:           wake = event_now | irq_ready;
            default:           wake = 1'b0;
        endcase
    end

    // Next state selection
    always_comb begin
        state_d = state;
        case (state)
            SLP_AWAKE: begin
                if (wfi_go)
                    state_d = SLP_WFI;
                else if (wfe_go && !wfe_hit)
                    state_d = SLP_WFE;
                else if (exc_ret && on_exit)
                    state_d = SLP_EXIT;
            end
            default: begin
                if (wake)
                    state_d = SLP_AWAKE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SLP_AWAKE;
        else
            state <= state_d;
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
// Module: top of the sleep and wake-event controller.
// Joins the control register, the event unit and the sleep state machine.
// Assumes: instruction strobes arrive only from an awake core; strobes
// seen while sleeping are ignored.
module sleep_wake_ctrl
    import slpw_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          DATA_W  = 32,
    parameter int          N_IRQ   = 8,
    parameter logic [11:0] CFG_OFS = 12'hD10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wfi_exec,
    input  logic              wfe_exec,
    input  logic              sev_exec,
    input  logic              ext_event,
    input  logic              exc_ret_thread,
    input  logic [N_IRQ-1:0]  irq_pend,
    input  logic [N_IRQ-1:0]  irq_en,
    output logic              sleeping,
    output logic              deep_sleep,
    output logic              wake_pulse
);
    slp_cfg_t   cfg;
    slp_state_e state;
    logic       awake;
    logic       wfi_go;
    logic       wfe_go;
    logic       in_wfe;
    logic       event_now;
    logic       latch_q;
    logic       irq_ready;
    logic       wake;

    // Gate instruction strobes with the awake state
    always_comb begin
        awake  = (state == SLP_AWAKE);
        in_wfe = (state == SLP_WFE);
        wfi_go = wfi_exec & awake;
        wfe_go = wfe_exec & awake & ~wfi_exec;
    end

    slpw_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_OFS (CFG_OFS)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    slpw_event_unit #(
        .N_IRQ (N_IRQ)
    ) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_event (cfg.pend_event),
        .sev        (sev_exec),
        .ext        (ext_event),
        .irq_pend   (irq_pend),
        .irq_en     (irq_en),
        .wfe_take   (wfe_go),
        .in_wfe     (in_wfe),
        .event_now  (event_now),
        .latch_q    (latch_q),
        .irq_ready  (irq_ready)
    );

    slpw_sleep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi_go    (wfi_go),
        .wfe_go    (wfe_go),
        .exc_ret   (exc_ret_thread),
        .on_exit   (cfg.on_exit),
        .event_now (event_now),
        .latch_q   (latch_q),
        .irq_ready (irq_ready),
        .state     (state),
        .wake      (wake)
    );

    // Drive the status outputs
    always_comb begin
        sleeping   = ~awake;
        deep_sleep = ~awake & cfg.deep;
        wake_pulse = wake;
    end
endmodule

// File: rtl/slpw_chk.sv
// Module: property checker bound to the top of the sleep/wake controller.
// Assumes: single-cycle, mutually exclusive instruction strobes.
module slpw_chk (
    input logic clk,
    input logic rst_n,
    input logic wfi_exec,
    input logic wfe_exec,
    input logic sev_exec,
    input logic ext_event,
    input logic exc_ret_thread,
    input logic sleeping,
    input logic deep_sleep,
    input logic wake_pulse,
    input logic cfg_on_exit,
    input logic in_wfe
);
    // R10
    deep_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> sleeping);

    // R11
    wake_while_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> sleeping);

    // R11
    wake_ends_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !sleeping);

    // R3
    sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !wake_pulse) |=> sleeping);

    // R3
    wfi_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && wfi_exec) |=> sleeping);

    // R9
    exit_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && exc_ret_thread && cfg_on_exit && !wfi_exec && !wfe_exec) |=> sleeping);

    // R5
    event_wakes_wfe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wfe && (sev_exec || ext_event)) |-> wake_pulse);
endmodule

bind sleep_wake_ctrl slpw_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wfi_exec       (wfi_exec),
    .wfe_exec       (wfe_exec),
    .sev_exec       (sev_exec),
    .ext_event      (ext_event),
    .exc_ret_thread (exc_ret_thread),
    .sleeping       (sleeping),
    .deep_sleep     (deep_sleep),
    .wake_pulse     (wake_pulse),
    .cfg_on_exit    (cfg.on_exit),
    .in_wfe         (in_wfe)
);

// File: tb/sim_sleep_wake_ctrl.sv
// Bench: a vector table walked by one loop, then directed register and reset tests.
module sim_sleep_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = 12'hD10;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wfi_exec = 1'b0, wfe_exec = 1'b0, sev_exec = 1'b0;
    logic        ext_event = 1'b0, exc_ret_thread = 1'b0;
    logic [7:0]  irq_pend = '0, irq_en = '0;
    logic        sleeping, deep_sleep, wake_pulse;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sleep_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wfi_exec(wfi_exec),
        .wfe_exec(wfe_exec), .sev_exec(sev_exec), .ext_event(ext_event),
        .exc_ret_thread(exc_ret_thread), .irq_pend(irq_pend), .irq_en(irq_en),
        .sleeping(sleeping), .deep_sleep(deep_sleep), .wake_pulse(wake_pulse)
    );

    // Vector: [24:20] req, [19] write, [18:16] cfg {pend_event,deep,on_exit},
    // [15:11] {wfi,wfe,sev,ext,exc}, [10:7] pend, [6:3] en,
    // [2:0] expected {sleeping after edge, deep after edge, wake before edge}
    localparam int NV = 29;
    localparam logic [24:0] VEC [NV] = '{
        {5'd1,  1'b0, 3'b000, 5'b00000, 4'h0, 4'h0, 3'b000}, // R1 idle
        {5'd3,  1'b0, 3'b000, 5'b10000, 4'h0, 4'h0, 3'b100}, // R3 WFI sleeps
        {5'd3,  1'b0, 3'b000, 5'b00000, 4'h1, 4'h0, 3'b100}, // R3 disabled pending no wake
        {5'd3,  1'b0, 3'b000, 5'b00000, 4'h1, 4'h1, 3'b001}, // R3 enabled pending wakes
        {5'd11, 1'b0, 3'b000, 5'b00000, 4'h0, 4'h0, 3'b000}, // R11 pulse gone
        {5'd4,  1'b0, 3'b000, 5'b01000, 4'h0, 4'h0, 3'b100}, // R4 WFE, latch clear
        {5'd5,  1'b0, 3'b000, 5'b00100, 4'h0, 4'h0, 3'b001}, // R5 SEV wakes WFE
        {5'd5,  1'b0, 3'b000, 5'b00100, 4'h0, 4'h0, 3'b000}, // R5 SEV awake sets latch
        {5'd4,  1'b0, 3'b000, 5'b01000, 4'h0, 4'h0, 3'b000}, // R4 WFE consumes latch
        {5'd4,  1'b0, 3'b000, 5'b01000, 4'h0, 4'h0, 3'b100}, // R4 next WFE sleeps
        {5'd5,  1'b0, 3'b000, 5'b00010, 4'h0, 4'h0, 3'b001}, // R5 external event wakes
        {5'd2,  1'b1, 3'b110, 5'b00000, 4'h0, 4'h0, 3'b000}, // R2 set pend_event, deep
        {5'd7,  1'b0, 3'b000, 5'b00000, 4'h2, 4'h0, 3'b000}, // R7 disabled rise latches
        {5'd4,  1'b0, 3'b000, 5'b01000, 4'h2, 4'h0, 3'b000}, // R4 WFE consumes it
        {5'd8,  1'b0, 3'b000, 5'b01000, 4'h2, 4'h0, 3'b110}, // R8 held level: sleeps
        {5'd8,  1'b0, 3'b000, 5'b00000, 4'h2, 4'h0, 3'b110}, // R8 still asleep
        {5'd7,  1'b0, 3'b000, 5'b00000, 4'h6, 4'h0, 3'b001}, // R7 new disabled rise wakes
        {5'd9,  1'b1, 3'b011, 5'b00000, 4'h0, 4'h0, 3'b000}, // R9 set deep, on_exit
        {5'd9,  1'b0, 3'b000, 5'b00001, 4'h0, 4'h0, 3'b110}, // R9 exc return sleeps
        {5'd9,  1'b0, 3'b000, 5'b00100, 4'h0, 4'h0, 3'b110}, // R9 SEV no wake, latches
        {5'd9,  1'b0, 3'b000, 5'b00000, 4'h1, 4'h1, 3'b001}, // R9 enabled pending wakes
        {5'd4,  1'b0, 3'b000, 5'b01000, 4'h0, 4'h0, 3'b000}, // R4 latch from WFI-type sleep
        {5'd2,  1'b1, 3'b000, 5'b00000, 4'h0, 4'h0, 3'b000}, // R2 clear word
        {5'd9,  1'b0, 3'b000, 5'b00001, 4'h0, 4'h0, 3'b000}, // R9 on_exit off: no sleep
        {5'd10, 1'b0, 3'b000, 5'b01000, 4'h0, 4'h0, 3'b100}, // R10 normal sleep, no deep
        {5'd6,  1'b0, 3'b000, 5'b00000, 4'h4, 4'h4, 3'b001}, // R6 enabled rise wakes
        {5'd6,  1'b0, 3'b000, 5'b01000, 4'h0, 4'h0, 3'b100}, // R6 no latch left: sleeps
        {5'd6,  1'b0, 3'b000, 5'b00000, 4'h8, 4'h0, 3'b100}, // R6 disabled rise ignored
        {5'd5,  1'b0, 3'b000, 5'b00100, 4'h8, 4'h0, 3'b001}  // R5 SEV wakes
    };

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_wr = 1'b0; wfi_exec = 1'b0; wfe_exec = 1'b0; sev_exec = 1'b0;
        ext_event = 1'b0; exc_ret_thread = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("sleeping", 1, 32'(sleeping), 32'd0);
        chk("deep_sleep", 1, 32'(deep_sleep), 32'd0);
        chk("wake_pulse", 1, 32'(wake_pulse), 32'd0);
        chk("rdata", 1, bus_rdata, 32'd0);

        // R2 reserved bits read zero
        @(negedge clk);
        bus_addr = 12'hD10; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; #1;
        chk("rdata all-ones write", 2, bus_rdata, 32'h0000_0016);
        // R2 other address ignored and reads zero
        bus_addr = 12'hD14; bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; #1;
        chk("rdata other address", 2, bus_rdata, 32'd0);
        bus_addr = 12'hD10; #1;
        chk("rdata after other write", 2, bus_rdata, 32'h0000_0016);
        bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr    = VEC[i][19];
            bus_wdata = {27'd0, VEC[i][18], 1'b0, VEC[i][17], VEC[i][16], 1'b0};
            {wfi_exec, wfe_exec, sev_exec, ext_event, exc_ret_thread} = VEC[i][15:11];
            irq_pend  = {4'h0, VEC[i][10:7]};
            irq_en    = {4'h0, VEC[i][6:3]};
            #1;
            chk($sformatf("step %0d wake_pulse", i), int'(VEC[i][24:20]), 32'(wake_pulse), 32'(VEC[i][0]));
            @(posedge clk);
            #1;
            chk($sformatf("step %0d sleeping", i), int'(VEC[i][24:20]), 32'(sleeping), 32'(VEC[i][2]));
            chk($sformatf("step %0d deep_sleep", i), int'(VEC[i][24:20]), 32'(deep_sleep), 32'(VEC[i][1]));
        end

        // R1 reset while in deep sleep with the latch set
        @(negedge clk);
        idle_inputs(); irq_pend = '0; irq_en = '0;
        bus_wdata = 32'h4; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sev_exec = 1'b1;
        @(negedge clk);
        sev_exec = 1'b0; wfi_exec = 1'b1;
        @(negedge clk);
        wfi_exec = 1'b0; #1;
        chk("deep before reset", 10, 32'(deep_sleep), 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("sleeping after reset", 1, 32'(sleeping), 32'd0);
        chk("rdata after reset", 1, bus_rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; wfe_exec = 1'b1;
        @(posedge clk);
        #1;
        chk("WFE sleeps after reset cleared latch", 1, 32'(sleeping), 32'd1);
        @(negedge clk);
        wfe_exec = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule